// File: doc/BRIEF.md
# Pin-Mapped Glitchless Frequency Selector

The block drives six clock channels. Each channel has two source clocks: its first frequency on `src_a` and its second on `src_b`. The channel outputs exactly one of them at a time. Two asynchronous frequency-select pins steer the channels. A static mapping word gives each channel a 2-bit code that ties it to pin 0, to pin 1, or to no pin. Any subset of channels may follow either pin. When the effective select of a channel changes, the output hands over without a glitch. The old clock finishes its cycle and then holds low. The new clock appears from its own next rising edge.

Each channel contains a handover state machine that runs on the falling edge of `src_a`. Its states are:

- `ST_A_WAIT`: both enables are off.
- `ST_A_RUN`: the first clock is gated through.
- `ST_B_REQ`: a grant is sent to the `src_b` domain, and the machine waits for its acknowledgement.
- `ST_B_RUN`: the second clock is gated through.
- `ST_B_DROP`: the grant is withdrawn, and the machine waits until the `src_b` domain reports that it is off.

Its transitions are:

- `ST_A_WAIT` goes to `ST_B_REQ` when the select is 1, or to `ST_A_RUN` when the select is 0 and the acknowledgement is low.
- `ST_A_RUN` goes to `ST_B_REQ` when the select rises.
- `ST_B_REQ` goes to `ST_B_RUN` on the acknowledgement.
- `ST_B_RUN` goes to `ST_B_DROP` when the select falls.
- `ST_B_DROP` goes to `ST_A_WAIT` once the acknowledgement clears.

The `src_b` domain enables its clock on its own falling edge, following a synchronised copy of the grant. The select and the acknowledgement each cross into the `src_a` domain through a two-flop synchroniser. The grant crosses into the `src_b` domain the same way.

Top module: `fsel_top`

## Requirements
- R1: While `rst_n` is low, every `ch_clk` bit is 0.
- R2: After reset, every channel outputs its `src_a` clock, and its first high pulse lasts a full `src_a` half period.
- R3: A channel whose map code is 2'b01 (map bits [2c+1:2c] for channel c) outputs `src_b` when `fs_pin[0]` is 1 and `src_a` when it is 0.
- R4: A channel whose map code is 2'b10 outputs `src_b` when `fs_pin[1]` is 1 and `src_a` when it is 0.
- R5: A channel whose map code is 2'b00 or 2'b11 outputs `src_a` whatever the `fs_pin` values.
- R6: Channels are independent: any mix of codes across the six channels gives each channel the output its own code and pins call for.
- R7: No high or low pulse on `ch_clk` is shorter than the shorter half period of that channel's two sources, and the two source enables are never on together.
- R8: The new source is enabled only after the other domain confirms its source is off. A burst of select toggles ends with the channel on the clock chosen by the final select value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | NCH | First-frequency source clock, one per channel |
| src_b | input | NCH | Second-frequency source clock, one per channel |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_pin | input | 2 | Asynchronous frequency-select pins |
| pin_map | input | 2*NCH | Per-channel 2-bit code: 00 no pin, 01 pin 0, 10 pin 1, 11 no pin |
| ch_clk | output | NCH | Gated output clock per channel |

## Verification
The hardest situation to reach from the ports is a select that reverses while a handover is still in flight. In that case one domain has released, or is about to claim, its clock before the other domain has seen the change. The stimulus reaches it with bursts of select toggles spaced closer than the synchroniser and handshake latency. Random mapping and pin values are also applied between settling windows, and the sources run at three unrelated periods. A sampler measures every output pulse at 1 ns resolution against the shorter half period, and a settled high-pulse width then shows which source won.

// File: rtl/fsel_pkg.sv
`timescale 1ns/1ps
package fsel_pkg;

    typedef enum logic [1:0] {
        MAP_NONE  = 2'b00,
        MAP_FS0   = 2'b01,
        MAP_FS1   = 2'b10,
        MAP_SPARE = 2'b11
    } map_code_e;

    typedef enum logic [2:0] {
        ST_A_WAIT,
        ST_A_RUN,
        ST_B_REQ,
        ST_B_RUN,
        ST_B_DROP
    } sw_state_e;

    function automatic logic pick_sel(map_code_e code, logic [1:0] pins);
        logic s;
        unique case (code)
            MAP_FS0: s = pins[0];
            MAP_FS1: s = pins[1];
            default: s = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fsel_sync.sv
`timescale 1ns/1ps
module fsel_sync #(
    parameter int STAGES  = 2,
    parameter bit ON_FALL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        if (ON_FALL) begin : g_fall
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[STAGES-2:0], d};
            end
        end else begin : g_rise
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh[STAGES-1];
endmodule

// File: rtl/fsel_chan.sv
`timescale 1ns/1ps
module fsel_chan
    import fsel_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic sel_raw,
    output logic clk_out
);
    sw_state_e state, nxt;
    logic      sel_s;
    logic      ack_s;
    logic      grant;
    logic      grant_s;
    logic      en_a;
    logic      en_b;

    fsel_sync #(.STAGES(STAGES), .ON_FALL(1'b1)) u_sel_a (
        .clk(clk_a), .rst_n(rst_n), .d(sel_raw), .q(sel_s));
    fsel_sync #(.STAGES(STAGES), .ON_FALL(1'b1)) u_ack_a (
        .clk(clk_a), .rst_n(rst_n), .d(en_b), .q(ack_s));
    fsel_sync #(.STAGES(STAGES), .ON_FALL(1'b1)) u_grant_b (
        .clk(clk_b), .rst_n(rst_n), .d(grant), .q(grant_s));

    // next-state decision, src_a domain
    always_comb begin
        nxt = state;
        unique case (state)
            ST_A_WAIT: begin
                if (sel_s)       nxt = ST_B_REQ;
                else if (!ack_s) nxt = ST_A_RUN;
            end
            ST_A_RUN:  if (sel_s)  nxt = ST_B_REQ;
            ST_B_REQ:  if (ack_s)  nxt = ST_B_RUN;
            ST_B_RUN:  if (!sel_s) nxt = ST_B_DROP;
            ST_B_DROP: if (!ack_s) nxt = ST_A_WAIT;
            default:   nxt = ST_A_WAIT;
        endcase
    end

    // state register
    always_ff @(negedge clk_a or negedge rst_n) begin
        if (!rst_n) state <= ST_A_WAIT;
        else        state <= nxt;
    end

    // registered outputs, so the clock gate never sees a decode glitch
    always_ff @(negedge clk_a or negedge rst_n) begin
        if (!rst_n) begin
            en_a  <= 1'b0;
            grant <= 1'b0;
        end else begin
            en_a  <= (nxt == ST_A_RUN);
            grant <= (nxt == ST_B_REQ) || (nxt == ST_B_RUN);
        end
    end

    // src_b domain: follow the synchronised grant on the falling edge
    always_ff @(negedge clk_b or negedge rst_n) begin
        if (!rst_n) en_b <= 1'b0;
        else        en_b <= grant_s;
    end

    assign clk_out = (clk_a & en_a) | (clk_b & en_b);

    // R7: the two gates are never open together
    p_excl_a_r7: assert property (@(posedge clk_a) disable iff (!rst_n)
        !(en_a && en_b));
    p_excl_b_r7: assert property (@(posedge clk_b) disable iff (!rst_n)
        !(en_a && en_b));
    // R8: a gate opens only while the other domain's gate is closed
    p_a_after_b_r8: assert property (@(negedge clk_a) disable iff (!rst_n)
        $rose(en_a) |-> !en_b);
    p_b_after_a_r8: assert property (@(negedge clk_b) disable iff (!rst_n)
        $rose(en_b) |-> !en_a);
endmodule

// File: rtl/fsel_top.sv
`timescale 1ns/1ps
module fsel_top
    import fsel_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int STAGES = 2
) (
    input  logic [NCH-1:0]   src_a,
    input  logic [NCH-1:0]   src_b,
    input  logic             rst_n,
    input  logic [1:0]       fs_pin,
    input  logic [2*NCH-1:0] pin_map,
    output logic [NCH-1:0]   ch_clk
);
    localparam int MAPW = 2;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            map_code_e code;
            logic      sel;

            assign code = map_code_e'(pin_map[MAPW*c +: MAPW]);
            assign sel  = pick_sel(code, fs_pin);

            fsel_chan #(.STAGES(STAGES)) u_chan (
                .clk_a   (src_a[c]),
                .clk_b   (src_b[c]),
                .rst_n   (rst_n),
                .sel_raw (sel),
                .clk_out (ch_clk[c])
            );
        end
    endgenerate
endmodule

// File: tb/test_fsel_top.sv
`timescale 1ns/1ps
module test_fsel_top;
    localparam int NCH = 6;

    logic              clk   = 1'b0;   // 50 MHz, first source of every channel
    logic              fast  = 1'b0;   // 14 ns period
    logic              slow  = 1'b0;   // 34 ns period
    logic              rst_n = 1'b1;
    logic [1:0]        fs    = 2'b00;
    logic [2*NCH-1:0]  pmap  = '0;
    wire  [NCH-1:0]    ch_clk;
    wire  [NCH-1:0]    src_a = {NCH{clk}};
    wire  [NCH-1:0]    src_b = {slow, fast, slow, fast, slow, fast};

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int   run_len  [NCH];
    logic lvl      [NCH];
    int   hi_cnt   [NCH];
    int   last_hi  [NCH];
    int   first_hi [NCH];

    initial begin #1.25; forever #10 clk  = ~clk;  end
    initial begin #1.25; forever #7  fast = ~fast; end
    initial begin #1.25; forever #17 slow = ~slow; end

    fsel_top #(.NCH(NCH)) i_fsel_top (
        .src_a(src_a), .src_b(src_b), .rst_n(rst_n),
        .fs_pin(fs), .pin_map(pmap), .ch_clk(ch_clk));

    function automatic int half_of(int ch, logic [2*NCH-1:0] m, logic [1:0] f);
        logic [1:0] c;
        logic       s;
        c = m[2*ch +: 2];
        s = (c == 2'b01) ? f[0] : (c == 2'b10) ? f[1] : 1'b0;
        if (!s) return 10;
        return (ch % 2 == 0) ? 7 : 17;
    endfunction

    function automatic int min_half(int ch);
        return (ch % 2 == 0) ? 7 : 10;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // 1 ns sampler, off the source edges (which fall at .25)
    initial begin
        for (int i = 0; i < NCH; i++) begin
            run_len[i] = 0; lvl[i] = 1'b0; hi_cnt[i] = 0;
            last_hi[i] = 0; first_hi[i] = 0;
        end
        forever begin
            #1;
            if (done) break;
            for (int i = 0; i < NCH; i++) begin
                if (ch_clk[i] === lvl[i]) run_len[i]++;
                else begin
                    if (rst_n)  // R7: every completed pulse is long enough
                        check(run_len[i] >= min_half(i), "R7 pulse width", run_len[i], min_half(i));
                    if (lvl[i] === 1'b1) begin
                        last_hi[i] = run_len[i];
                        if (hi_cnt[i] == 0) first_hi[i] = run_len[i];
                        hi_cnt[i]++;
                    end
                    lvl[i]     = ch_clk[i];
                    run_len[i] = 1;
                end
            end
        end
    end

    task automatic meas(int ch, string req, int exp);
        int start;
        int n;
        start = hi_cnt[ch];
        n     = 0;
        while (hi_cnt[ch] < start + 2 && n < 400) begin #1; n++; end
        if (hi_cnt[ch] < start + 2) check(1'b0, req, -1, exp);
        else check(last_hi[ch] == exp, req, last_hi[ch], exp);
    endtask

    task automatic settle_check(string req);
        #400;
        for (int i = 0; i < NCH; i++) meas(i, req, half_of(i, pmap, fs));
    endtask

    initial begin
        #0.5 rst_n = 1'b0;
        #5;
        check(ch_clk == '0, "R1 low in reset", int'(ch_clk), 0);
        fs = 2'b11; pmap = {NCH{2'b01}};
        #55;
        check(ch_clk == '0, "R1 low in reset, pins active", int'(ch_clk), 0);
        fs = 2'b00; pmap = '0;
        #40 rst_n = 1'b1;
        #300;
        for (int i = 0; i < NCH; i++) begin
            check(hi_cnt[i] > 0, "R2 output started", hi_cnt[i], 1);
            check(first_hi[i] == 10, "R2 first pulse full width", first_hi[i], 10);
        end
        settle_check("R2 first source after reset");

        pmap = {NCH{2'b01}}; fs = 2'b01; settle_check("R3 pin0 high");
        fs = 2'b10;                      settle_check("R3 pin0 low, pin1 ignored");
        pmap = {NCH{2'b10}}; fs = 2'b10; settle_check("R4 pin1 high");
        fs = 2'b01;                      settle_check("R4 pin1 low, pin0 ignored");
        pmap = {NCH{2'b00}}; fs = 2'b11; settle_check("R5 code 00 ignores pins");
        pmap = {NCH{2'b11}}; fs = 2'b11; settle_check("R5 code 11 ignores pins");

        pmap = 12'b01_10_01_10_10_01; fs = 2'b01; settle_check("R6 mixed map pin0");
        fs = 2'b10;                               settle_check("R6 mixed map pin1");

        // R8: toggle bursts faster than the handover latency
        pmap = {NCH{2'b01}}; fs = 2'b00; settle_check("R8 start");
        for (int k = 0; k < 21; k++) begin #13 fs[0] = ~fs[0]; end
        settle_check("R8 burst ending high");
        for (int k = 0; k < 15; k++) begin #9 fs[0] = ~fs[0]; end
        settle_check("R8 burst ending low");

        void'($urandom(32'd4242));
        for (int k = 0; k < 20; k++) begin
            pmap = 12'($urandom);
            fs   = 2'($urandom);
            if (k % 4 == 3) begin
                for (int j = 0; j < 6; j++) begin #11 fs = 2'($urandom); end
            end
            settle_check("R6 random map and pins");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #150000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule